// File: doc/BRIEF.md
# Host/Reconfigurable Instruction Arbiter

This block sits between instruction fetch and two consumers: a general-purpose core and a reconfigurable coprocessor with its own microcode sequencer. It decodes each fetched word. Ordinary instructions pass to the core. A small fixed group of added instructions is taken away from the core, and the core receives a no-operation word in their place. A configure instruction and an execute instruction each carry an address that is handed to the coprocessor. The configure request is what starts the loading of microcode. There are no function-specific opcodes. Two move instructions copy values between core registers and a dedicated exchange register file. The coprocessor uses that file to read its parameters and to write its results.

Each execute names an operation slot and the exchange register that will receive its result. Executes on different free slots can be issued back to back, so independent operations run in parallel. The block keeps a busy bit per slot. A read-back of a pending result, a reuse of a busy slot and a synchronisation instruction all stall fetch until the slots they wait on have finished. This keeps results in program order.

Top module: `rcarb_arbiter`

## Requirements
- R1: After reset, core_valid, cu_valid and fx_valid are low, no slot is busy, and f_stall is low.
- R2: An instruction word whose bits [31:26] are not 6'h3B is accepted when f_valid is high and f_stall is low. One cycle later it appears unchanged on core_instr with core_valid high and cu_valid low.
- R3: An added instruction is marked by bits [31:26]=6'h3B, and bits [25:23] give its function. Function 0 is configure. One cycle after it is accepted, cu_valid is high, cu_exec is low, cu_addr equals bits [22:0], and the core receives NOP_WORD with core_valid high.
- R4: Function 1 is execute, with slot in [22:21], result register in [20:12] and address in [11:0]. One cycle after it is accepted, cu_valid and cu_exec are high, cu_slot is the slot, cu_addr is the address zero-extended, and the slot becomes busy. An execute that names a busy slot stalls until the cycle after that slot's cu_done pulse.
- R5: Function 2 (core register [22:18], exchange register [8:0]) writes src_data into the exchange register. The value can be read by a following instruction and on cu_rd_data one cycle after cu_rd_addr is presented.
- R6: Function 3 (core register [22:18], exchange register [8:0]) reads the exchange register. One cycle after it is accepted, fx_valid is high, fx_reg is the core register, fx_data is the register content, and the core receives NOP_WORD.
- R7: A function-3 read of a register that is the result of a busy slot stalls until the cycle after that slot's cu_done pulse. A read of any other register proceeds without waiting.
- R8: Function 4 (synchronise) stalls while any slot is busy. It then reaches the core as NOP_WORD and has no other effect.
- R9: Executes on different free slots are accepted on consecutive cycles without stalling.
- R10: The coprocessor write port (cu_wr_en) updates the exchange register file. When it writes the same register in the same cycle as a function-2 move, the move's value is kept.
- R11: Functions 5 to 7 reach the core as NOP_WORD. They raise neither cu_valid nor fx_valid and leave the exchange registers unchanged.
- R12: While f_stall is high, the instruction is not consumed and core_valid stays low in the next cycle. A cu_done pulse for an idle slot has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_valid | input | 1 | Fetched instruction present |
| f_instr | input | 32 | Fetched instruction word |
| src_data | input | XR_W | Core source register value for a move into the exchange file |
| f_stall | output | 1 | Instruction held; fetch must keep presenting it |
| core_valid | output | 1 | Instruction issued to the core |
| core_instr | output | 32 | Original word, or NOP_WORD for a redirected instruction |
| cu_valid | output | 1 | Request to the coprocessor sequencer |
| cu_exec | output | 1 | 1 for execute, 0 for configure (microcode load) |
| cu_slot | output | SL_W | Operation slot of an execute |
| cu_addr | output | 23 | Microcode address |
| cu_done | input | NSLOT | One-cycle completion pulse per slot |
| cu_wr_en | input | 1 | Coprocessor writes an exchange register |
| cu_wr_addr | input | XA_W | Coprocessor write index |
| cu_wr_data | input | XR_W | Coprocessor write value |
| cu_rd_addr | input | XA_W | Coprocessor read index |
| cu_rd_data | output | XR_W | Registered coprocessor read value |
| fx_valid | output | 1 | Read-back value for the core is present |
| fx_reg | output | 5 | Core destination register |
| fx_data | output | XR_W | Value read from the exchange file |

## Verification
Every accepted instruction produces exactly one core_valid cycle, together with its coprocessor or read-back fields, one clock after the accepting edge. The driver pushes the expected item at that edge, and a monitor pops it at the following falling edge. A stall is measured as the number of falling edges at which f_stall is seen high before acceptance. For a done pulse raised three edges after the attempt, the expected count is four, because busy clears on the edge that samples the pulse. The coprocessor read port is checked one falling edge after its address is set.

// File: rtl/rcarb_pkg.sv
package rcarb_pkg;
    localparam int INSTR_W = 32;
    localparam int PAY_W   = 23;   // bits below opcode and function

    typedef enum logic [2:0] {
        K_CORE, K_SET, K_EXEC, K_MOVTX, K_MOVFX, K_SYNC, K_RSV
    } kind_e;
endpackage

// File: rtl/rcarb_decode.sv
module rcarb_decode
    import rcarb_pkg::*;
#(
    parameter logic [5:0] EXT_OPC = 6'h3B,
    parameter int SL_W = 2,
    parameter int XA_W = 9,
    localparam int EA_W = PAY_W - SL_W - XA_W
) (
    input  logic [INSTR_W-1:0] instr,
    output kind_e              kind,
    output logic [SL_W-1:0]    slot,
    output logic [XA_W-1:0]    res_xr,
    output logic [PAY_W-1:0]   mc_addr,
    output logic [XA_W-1:0]    xr_idx,
    output logic [4:0]         core_reg
);
    logic [PAY_W-1:0] pay;
    assign pay = instr[PAY_W-1:0];

    always_comb begin
        kind = K_CORE;
        if (instr[31:26] == EXT_OPC) begin
            unique case (instr[25:23])
                3'd0:    kind = K_SET;
                3'd1:    kind = K_EXEC;
                3'd2:    kind = K_MOVTX;
                3'd3:    kind = K_MOVFX;
                3'd4:    kind = K_SYNC;
                default: kind = K_RSV;
            endcase
        end
    end

    assign slot     = pay[PAY_W-1 -: SL_W];
    assign res_xr   = pay[PAY_W-1-SL_W -: XA_W];
    assign mc_addr  = (kind == K_EXEC) ? {{(PAY_W-EA_W){1'b0}}, pay[EA_W-1:0]} : pay;
    assign xr_idx   = pay[XA_W-1:0];
    assign core_reg = pay[PAY_W-1 -: 5];
endmodule

// File: rtl/rcarb_busy.sv
module rcarb_busy #(
    parameter int NSLOT = 4,
    parameter int XA_W  = 9,
    localparam int SL_W = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [SL_W-1:0]  set_slot,
    input  logic [XA_W-1:0]  set_xr,
    input  logic [NSLOT-1:0] done,
    input  logic [XA_W-1:0]  q_xr,
    output logic [NSLOT-1:0] busy,
    output logic             q_hit,
    output logic             any_busy
);
    typedef struct packed {
        logic [NSLOT-1:0]           busy;
        logic [NSLOT-1:0][XA_W-1:0] res;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.busy = st_q.busy & ~done;
        if (set_en) begin
            st_d.busy[set_slot] = 1'b1;
            st_d.res[set_slot]  = set_xr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        q_hit = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            if (st_q.busy[i] && st_q.res[i] == q_xr) q_hit = 1'b1;
        end
    end

    assign busy     = st_q.busy;
    assign any_busy = |st_q.busy;
endmodule

// File: rtl/rcarb_xrf.sv
module rcarb_xrf #(
    parameter int DEPTH = 512,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_we,
    input  logic [AW-1:0] a_addr,
    input  logic [W-1:0]  a_wd,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [W-1:0]  b_wd,
    input  logic [AW-1:0] r_addr,
    output logic [W-1:0]  r_data,
    input  logic [AW-1:0] c_addr,
    output logic [W-1:0]  c_data
);
    logic [W-1:0] mem [DEPTH];

    // Core port is written last so it wins a same-address collision.
    always_ff @(posedge clk) begin
        if (b_we) mem[b_addr] <= b_wd;
        if (a_we) mem[a_addr] <= a_wd;
    end

    assign r_data = mem[r_addr];

    logic [W-1:0] c_data_d, c_data_q;
    assign c_data_d = mem[c_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) c_data_q <= '0;
        else        c_data_q <= c_data_d;
    end

    assign c_data = c_data_q;
endmodule

// File: rtl/rcarb_arbiter.sv
module rcarb_arbiter
    import rcarb_pkg::*;
#(
    parameter int NSLOT    = 4,
    parameter int XR_DEPTH = 512,
    parameter int XR_W     = 32,
    parameter logic [5:0]  EXT_OPC  = 6'h3B,
    parameter logic [31:0] NOP_WORD = 32'h0000_0000,
    localparam int SL_W = $clog2(NSLOT),
    localparam int XA_W = $clog2(XR_DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               f_valid,
    input  logic [INSTR_W-1:0] f_instr,
    input  logic [XR_W-1:0]    src_data,
    output logic               f_stall,
    output logic               core_valid,
    output logic [INSTR_W-1:0] core_instr,
    output logic               cu_valid,
    output logic               cu_exec,
    output logic [SL_W-1:0]    cu_slot,
    output logic [PAY_W-1:0]   cu_addr,
    input  logic [NSLOT-1:0]   cu_done,
    input  logic               cu_wr_en,
    input  logic [XA_W-1:0]    cu_wr_addr,
    input  logic [XR_W-1:0]    cu_wr_data,
    input  logic [XA_W-1:0]    cu_rd_addr,
    output logic [XR_W-1:0]    cu_rd_data,
    output logic               fx_valid,
    output logic [4:0]         fx_reg,
    output logic [XR_W-1:0]    fx_data
);
    kind_e            kind;
    logic [SL_W-1:0]  slot;
    logic [XA_W-1:0]  res_xr, xr_idx;
    logic [PAY_W-1:0] mc_addr;
    logic [4:0]       core_reg;
    logic [NSLOT-1:0] busy;
    logic             fx_hit, any_busy, accept;
    logic [XR_W-1:0]  xr_rdata;

    rcarb_decode #(.EXT_OPC(EXT_OPC), .SL_W(SL_W), .XA_W(XA_W)) u_dec (
        .instr(f_instr), .kind(kind), .slot(slot), .res_xr(res_xr),
        .mc_addr(mc_addr), .xr_idx(xr_idx), .core_reg(core_reg)
    );

    rcarb_busy #(.NSLOT(NSLOT), .XA_W(XA_W)) u_busy (
        .clk(clk), .rst_n(rst_n),
        .set_en(accept && kind == K_EXEC), .set_slot(slot), .set_xr(res_xr),
        .done(cu_done), .q_xr(xr_idx),
        .busy(busy), .q_hit(fx_hit), .any_busy(any_busy)
    );

    rcarb_xrf #(.DEPTH(XR_DEPTH), .W(XR_W)) u_xrf (
        .clk(clk), .rst_n(rst_n),
        .a_we(accept && kind == K_MOVTX), .a_addr(xr_idx), .a_wd(src_data),
        .b_we(cu_wr_en), .b_addr(cu_wr_addr), .b_wd(cu_wr_data),
        .r_addr(xr_idx), .r_data(xr_rdata),
        .c_addr(cu_rd_addr), .c_data(cu_rd_data)
    );

    // Join conditions: slot reuse, pending result read-back, full sync.
    assign f_stall = f_valid && ((kind == K_EXEC  && busy[slot]) ||
                                 (kind == K_MOVFX && fx_hit)     ||
                                 (kind == K_SYNC  && any_busy));
    assign accept  = f_valid && !f_stall;

    typedef struct packed {
        logic               core_valid;
        logic [INSTR_W-1:0] core_instr;
        logic               cu_valid;
        logic               cu_exec;
        logic [SL_W-1:0]    cu_slot;
        logic [PAY_W-1:0]   cu_addr;
        logic               fx_valid;
        logic [4:0]         fx_reg;
        logic [XR_W-1:0]    fx_data;
    } out_t;

    out_t o_d, o_q;

    always_comb begin
        o_d            = '0;
        o_d.core_instr = NOP_WORD;
        if (accept) begin
            o_d.core_valid = 1'b1;
            if (kind == K_CORE) o_d.core_instr = f_instr;
            if (kind == K_SET || kind == K_EXEC) begin
                o_d.cu_valid = 1'b1;
                o_d.cu_exec  = (kind == K_EXEC);
                o_d.cu_addr  = mc_addr;
                o_d.cu_slot  = (kind == K_EXEC) ? slot : '0;
            end
            if (kind == K_MOVFX) begin
                o_d.fx_valid = 1'b1;
                o_d.fx_reg   = core_reg;
                o_d.fx_data  = xr_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q            <= '0;
            o_q.core_instr <= NOP_WORD;
        end else begin
            o_q <= o_d;
        end
    end

    assign core_valid = o_q.core_valid;
    assign core_instr = o_q.core_instr;
    assign cu_valid   = o_q.cu_valid;
    assign cu_exec    = o_q.cu_exec;
    assign cu_slot    = o_q.cu_slot;
    assign cu_addr    = o_q.cu_addr;
    assign fx_valid   = o_q.fx_valid;
    assign fx_reg     = o_q.fx_reg;
    assign fx_data    = o_q.fx_data;
endmodule

// File: rtl/rcarb_chk.sv
module rcarb_chk #(
    parameter logic [31:0] NOP_WORD = 32'h0
) (
    input logic        clk,
    input logic        rst_n,
    input logic        f_valid,
    input logic        f_stall,
    input logic        core_valid,
    input logic [31:0] core_instr,
    input logic        cu_valid,
    input logic        fx_valid
);
    // R12: a stall is only raised against a presented instruction
    p_stall_needs_fetch_r12: assert property (@(posedge clk) disable iff (!rst_n)
        f_stall |-> f_valid);

    // R12: a stalled cycle issues nothing
    p_stall_no_issue_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (f_valid && f_stall) |=> !core_valid);

    // R3: a coprocessor request replaces the core instruction with a no-op
    p_cu_nop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cu_valid |-> (core_valid && core_instr == NOP_WORD));

    // R6: a read-back replaces the core instruction with a no-op
    p_fx_nop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fx_valid |-> (core_valid && core_instr == NOP_WORD));

    // R6: a coprocessor request and a read-back never share a cycle
    p_one_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cu_valid && fx_valid));

    // R1: nothing is issued in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!core_valid && !cu_valid && !fx_valid));
endmodule

bind rcarb_arbiter rcarb_chk #(.NOP_WORD(NOP_WORD)) u_chk (
    .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_stall(f_stall),
    .core_valid(core_valid), .core_instr(core_instr),
    .cu_valid(cu_valid), .fx_valid(fx_valid)
);

// File: tb/sim_rcarb_arbiter.sv
`timescale 1ns/1ps
module sim_rcarb_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        f_valid = 1'b0;
    logic [31:0] f_instr = '0;
    logic [31:0] src_data = '0;
    logic        f_stall, core_valid, cu_valid, cu_exec, fx_valid;
    logic [31:0] core_instr, cu_rd_data, fx_data;
    logic [1:0]  cu_slot;
    logic [22:0] cu_addr;
    logic [3:0]  cu_done = '0;
    logic        cu_wr_en = 1'b0;
    logic [8:0]  cu_wr_addr = '0, cu_rd_addr = '0;
    logic [31:0] cu_wr_data = '0;
    logic [4:0]  fx_reg;

    localparam logic [31:0] NOP = 32'h0;

    always #2 clk = ~clk;

    rcarb_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .f_valid(f_valid), .f_instr(f_instr),
        .src_data(src_data), .f_stall(f_stall), .core_valid(core_valid),
        .core_instr(core_instr), .cu_valid(cu_valid), .cu_exec(cu_exec),
        .cu_slot(cu_slot), .cu_addr(cu_addr), .cu_done(cu_done),
        .cu_wr_en(cu_wr_en), .cu_wr_addr(cu_wr_addr), .cu_wr_data(cu_wr_data),
        .cu_rd_addr(cu_rd_addr), .cu_rd_data(cu_rd_data),
        .fx_valid(fx_valid), .fx_reg(fx_reg), .fx_data(fx_data)
    );

    int errors = 0;
    int checks = 0;

    typedef struct {
        logic [31:0] core_instr;
        logic        cu_valid;
        logic        cu_exec;
        logic [1:0]  cu_slot;
        logic [22:0] cu_addr;
        logic        fx_valid;
        logic [4:0]  fx_reg;
        logic [31:0] fx_data;
    } item_t;

    item_t       expq[$];
    string       tagq[$];
    logic [31:0] xm [512];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [2:0] fn, input logic [22:0] pay);
        return {6'h3B, fn, pay};
    endfunction
    function automatic logic [31:0] mk_exec(input logic [1:0] s, input logic [8:0] xr, input logic [11:0] a);
        return mk(3'd1, {s, xr, a});
    endfunction
    function automatic logic [31:0] mk_mov(input logic [2:0] fn, input logic [4:0] r, input logic [8:0] xr);
        return mk(fn, {r, 9'd0, xr});
    endfunction

    // Driver: present at a falling edge, count stalled edges, push expectation at accept.
    task automatic issue(input string tag, input logic [31:0] ins, input logic [31:0] src, output int waits);
        item_t it;
        f_valid = 1'b1; f_instr = ins; src_data = src; waits = 0;
        #1;
        while (f_stall) begin
            waits++;
            @(negedge clk); #1;
        end
        @(posedge clk);
        it = '{NOP, 1'b0, 1'b0, 2'd0, 23'd0, 1'b0, 5'd0, 32'd0};
        if (ins[31:26] != 6'h3B) it.core_instr = ins;
        else begin
            case (ins[25:23])
                3'd0: begin it.cu_valid = 1; it.cu_addr = ins[22:0]; end
                3'd1: begin it.cu_valid = 1; it.cu_exec = 1; it.cu_slot = ins[22:21];
                            it.cu_addr = {11'd0, ins[11:0]}; end
                3'd2: xm[ins[8:0]] = src;
                3'd3: begin it.fx_valid = 1; it.fx_reg = ins[22:18]; it.fx_data = xm[ins[8:0]]; end
                default: ;
            endcase
        end
        expq.push_back(it);
        tagq.push_back(tag);
        @(negedge clk);
        f_valid = 1'b0;
    endtask

    task automatic pulse_done_after(input int n, input logic [3:0] m);
        repeat (n) @(negedge clk);
        cu_done = m;
        @(negedge clk);
        cu_done = '0;
    endtask

    task automatic cu_write(input logic [8:0] a, input logic [31:0] d);
        cu_wr_en = 1'b1; cu_wr_addr = a; cu_wr_data = d; xm[a] = d;
        @(negedge clk);
        cu_wr_en = 1'b0;
    endtask

    // Monitor: one expected item per core_valid cycle.
    always @(negedge clk) begin
        if (rst_n && core_valid) begin
            item_t e;
            string t;
            if (expq.size() == 0) begin
                checks++; errors++;
                $display("FAIL R12 unexpected issue actual=%h expected=none", core_instr);
            end else begin
                e = expq.pop_front();
                t = tagq.pop_front();
                checks++;
                if (core_instr !== e.core_instr || cu_valid !== e.cu_valid || fx_valid !== e.fx_valid ||
                    (e.cu_valid && (cu_exec !== e.cu_exec || cu_slot !== e.cu_slot || cu_addr !== e.cu_addr)) ||
                    (e.fx_valid && (fx_reg !== e.fx_reg || fx_data !== e.fx_data))) begin
                    errors++;
                    $display("FAIL %s actual=%h/%b%b%h%h/%b%h%h expected=%h/%b%b%h%h/%b%h%h", t,
                        core_instr, cu_valid, cu_exec, cu_slot, cu_addr, fx_valid, fx_reg, fx_data,
                        e.core_instr, e.cu_valid, e.cu_exec, e.cu_slot, e.cu_addr, e.fx_valid, e.fx_reg, e.fx_data);
                end
            end
        end
    end

    bit finished = 0;
    initial begin
        #(4 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int w;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 core_valid", {31'd0, core_valid}, 32'd0);
        check("R1 cu_valid", {31'd0, cu_valid}, 32'd0);
        check("R1 fx_valid", {31'd0, fx_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 stall", {31'd0, f_stall}, 32'd0);

        issue("R2 ordinary", 32'h1234_5678, 0, w);
        issue("R2 ordinary high", 32'hFFFF_0000, 0, w);
        issue("R3 set", mk(3'd0, 23'h5A5A5), 0, w);

        issue("R5 movtx", mk_mov(3'd2, 5'd3, 9'd5), 32'hCAFE_F00D, w);
        issue("R6 movfx", mk_mov(3'd3, 5'd7, 9'd5), 0, w);
        cu_rd_addr = 9'd5;
        @(negedge clk);
        check("R5 cu read", cu_rd_data, 32'hCAFE_F00D);

        issue("R4 exec slot1", mk_exec(2'd1, 9'h010, 12'hABC), 0, w);
        check("R4 exec free no stall", w, 0);
        issue("R9 exec slot2", mk_exec(2'd2, 9'h020, 12'h123), 0, w);
        check("R9 back to back", w, 0);

        issue("R7 movfx unrelated", mk_mov(3'd3, 5'd1, 9'd5), 0, w);
        check("R7 unrelated no stall", w, 0);
        cu_write(9'h010, 32'h0000_1111);
        fork
            issue("R7 movfx pending", mk_mov(3'd3, 5'd9, 9'h010), 0, w);
            pulse_done_after(3, 4'b0010);
        join
        check("R7 stall length", w, 4);

        fork
            issue("R4 exec busy slot", mk_exec(2'd2, 9'h030, 12'h777), 0, w);
            pulse_done_after(3, 4'b0100);
        join
        check("R4 stall length", w, 4);

        fork
            issue("R8 sync busy", mk(3'd4, 23'h0), 0, w);
            pulse_done_after(3, 4'b0100);
        join
        check("R8 sync stall length", w, 4);
        issue("R8 sync idle", mk(3'd4, 23'h0), 0, w);
        check("R8 sync idle no stall", w, 0);

        fork
            cu_write(9'd9, 32'h0000_BBBB);
            issue("R10 movtx collide", mk_mov(3'd2, 5'd2, 9'd9), 32'h0000_AAAA, w);
        join
        issue("R10 collision winner", mk_mov(3'd3, 5'd4, 9'd9), 0, w);
        cu_write(9'd10, 32'h0BAD_0BAD);
        cu_rd_addr = 9'd10;
        @(negedge clk);
        check("R10 cu write", cu_rd_data, 32'h0BAD_0BAD);

        issue("R11 reserved", mk(3'd5, {5'd3, 9'd0, 9'd5}), 32'hDEAD_BEEF, w);
        issue("R11 reserved 7", mk(3'd7, 23'h7FFFFF), 0, w);
        issue("R11 xr unchanged", mk_mov(3'd3, 5'd6, 9'd5), 0, w);

        pulse_done_after(0, 4'b1000);
        issue("R12 exec after idle done", mk_exec(2'd0, 9'h040, 12'h001), 0, w);
        check("R12 idle done no effect", w, 0);
        fork
            issue("R12 stalled exec", mk_exec(2'd0, 9'h041, 12'h002), 0, w);
            pulse_done_after(3, 4'b0001);
        join
        check("R12 held until free", w, 4);
        pulse_done_after(0, 4'b0001);

        repeat (3) @(negedge clk);
        check("R12 queue drained", expq.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule